// File: doc/BRIEF.md
# Register Write-Protection Key Gate

This block decides whether a write on a peripheral's register bus may reach the protected register file. It watches a 32-bit write port. Protected registers take writes only after a two-step key sequence. First, a fixed magic word is written to the first key register. Then a second, different magic word is written to the second key register. Writing zero, or any other value, to either key register closes the gate again and restarts the sequence.

For every write, the block drives a same-cycle permit signal that the register file uses as its write enable. It also drives a registered open/closed status. A sticky flag records that a write to a protected address was refused while the gate was closed. Reads are not gated at all, so they need no port here. Writes to the key registers themselves are always permitted.

Top module: `wp_gate`

## Requirements
- R1: After synchronous reset the gate is closed (`unlocked`=0) and `wr_violation`=0.
- R2: A write to either key address (first key at byte address 0x6C, second at 0x70) gets `wr_permit`=1 in its own cycle, whatever the gate state and data.
- R3: While the gate is closed, a write to any non-key address gets `wr_permit`=0 in its own cycle, and `wr_violation` is 1 from the next cycle.
- R4: Writing 0x83E70B13 to the first key and then 0x95A4F1E0 to the second key opens the gate (`unlocked`=1) in the cycle after the second key write.
- R5: While the gate is open, writes to non-key addresses get `wr_permit`=1 and leave `wr_violation` unchanged.
- R6: Writing zero to either key address closes the gate from the next cycle.
- R7: Writing any value other than its magic word to a key address closes the gate and discards a pending first step. A later correct second-key write alone does not open the gate.
- R8: The second-key magic opens the gate only directly after a first-key magic write. Written with the gate closed and not armed, or with the gate already open, it leaves the gate closed.
- R9: Writes to non-key addresses between the two key steps do not break the sequence.
- R10: `wr_permit` is 0 when `wr_valid` is 0. Once set, `wr_violation` stays set until reset.
- R11: Writing the first-key magic while the gate is open closes it and re-arms the sequence, so a second-key magic write then reopens it.
- R12: Key addresses are matched on all address bits. A neighbouring byte address such as 0x6D is an ordinary protected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_permit | output | 1 | The current write may update its target |
| unlocked | output | 1 | Gate open for protected writes |
| wr_violation | output | 1 | Sticky: a protected write was refused |

## Verification
The key sequence is tried in the correct order, in reverse order, with a second-key repeat while open, and with a first-key repeat while open. Each case tells the armed step apart from the open state. Wrong key values are tried as zero, as an arbitrary word and as a one-bit miss of the magic, which shows that an exact 32-bit compare is made. Protected writes are placed before unlock, between the two steps and after unlock, and one goes to the byte right after a key address. These cases separate the same-cycle permit from the registered state and show that key decode uses the full address. A final reset shows that only reset clears the sticky flag.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

    localparam int unsigned KEY_W     = 32;
    localparam int unsigned NUM_KEYS  = 2;
    localparam logic [KEY_W-1:0] KEY0_MAGIC = 32'h83E7_0B13;
    localparam logic [KEY_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_KEY0  = 2'd1,
        WR_KEY1  = 2'd2,
        WR_OTHER = 2'd3
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e kind;
        logic     magic_ok;
    } wr_class_t;

    function automatic gate_state_e gate_next(gate_state_e cur, wr_class_t c);
        gate_state_e nxt;
        nxt = cur;
        case (c.kind)
            WR_KEY0: nxt = c.magic_ok ? ST_ARMED : ST_LOCKED;
            WR_KEY1: nxt = (c.magic_ok && cur == ST_ARMED) ? ST_OPEN : ST_LOCKED;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wp_key_decode.sv
module wp_key_decode
    import wp_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70,
    parameter logic [KEY_W-1:0] KEY0_VALUE = KEY0_MAGIC,
    parameter logic [KEY_W-1:0] KEY1_VALUE = KEY1_MAGIC
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output wr_class_t         wr_class
);
    localparam logic [NUM_KEYS*ADDR_W-1:0] KEY_ADDRS = {KEY1_ADDR, KEY0_ADDR};
    localparam logic [NUM_KEYS*KEY_W-1:0]  KEY_VALS  = {KEY1_VALUE, KEY0_VALUE};

    logic [NUM_KEYS-1:0] hit;
    logic [NUM_KEYS-1:0] good;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        assign hit[k]  = wr_valid && (wr_addr == KEY_ADDRS[k*ADDR_W +: ADDR_W]);
        assign good[k] = (wr_data == KEY_VALS[k*KEY_W +: KEY_W]);
    end

    always_comb begin
        wr_class.magic_ok = 1'b0;
        if (!wr_valid) begin
            wr_class.kind = WR_NONE;
        end else if (hit[0]) begin
            wr_class.kind     = WR_KEY0;
            wr_class.magic_ok = good[0];
        end else if (hit[1]) begin
            wr_class.kind     = WR_KEY1;
            wr_class.magic_ok = good[1];
        end else begin
            wr_class.kind = WR_OTHER;
        end
    end
endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
    import wp_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_class_t   wr_class,
    output gate_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCKED;
        else     state <= gate_next(state, wr_class);
    end
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
    import wp_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_class_t   wr_class,
    input  gate_state_e state,
    output logic        wr_permit,
    output logic        wr_violation
);
    logic refused;

    always_comb begin
        case (wr_class.kind)
            WR_KEY0, WR_KEY1: wr_permit = 1'b1;
            WR_OTHER:         wr_permit = (state == ST_OPEN);
            default:          wr_permit = 1'b0;
        endcase
        refused = (wr_class.kind == WR_OTHER) && (state != ST_OPEN);
    end

    always_ff @(posedge clk) begin
        if (rst)          wr_violation <= 1'b0;
        else if (refused) wr_violation <= 1'b1;
    end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wp_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70,
    parameter logic [KEY_W-1:0] KEY0_VALUE = KEY0_MAGIC,
    parameter logic [KEY_W-1:0] KEY1_VALUE = KEY1_MAGIC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output logic              wr_permit,
    output logic              unlocked,
    output logic              wr_violation
);
    wr_class_t   cls;
    gate_state_e state;

    wp_key_decode #(
        .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
        .KEY0_VALUE(KEY0_VALUE), .KEY1_VALUE(KEY1_VALUE)
    ) i_decode (
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_class(cls)
    );

    wp_key_fsm i_fsm (
        .clk(clk), .rst(rst), .wr_class(cls), .state(state)
    );

    wp_write_gate i_gate (
        .clk(clk), .rst(rst), .wr_class(cls), .state(state),
        .wr_permit(wr_permit), .wr_violation(wr_violation)
    );

    assign unlocked = (state == ST_OPEN);
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk
    import wp_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h70,
    parameter logic [KEY_W-1:0] KEY1_VALUE = KEY1_MAGIC
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [KEY_W-1:0]  wr_data,
    input logic              wr_permit,
    input logic              unlocked,
    input logic              wr_violation
);
    logic key_wr;
    assign key_wr = wr_valid && (wr_addr == KEY0_ADDR || wr_addr == KEY1_ADDR);

    p_reset_closed_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!unlocked && !wr_violation));

    p_key_permit_r2: assert property (@(posedge clk) disable iff (rst)
        key_wr |-> wr_permit);

    p_closed_block_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !key_wr && !unlocked) |-> !wr_permit);

    p_closed_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !key_wr && !unlocked) |=> wr_violation);

    p_open_via_key1_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(wr_valid && wr_addr == KEY1_ADDR && wr_data == KEY1_VALUE));

    p_open_permit_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && unlocked) |-> wr_permit);

    p_zero_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (key_wr && wr_data == '0) |=> !unlocked);

    p_idle_no_permit_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> !wr_permit);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        wr_violation |=> wr_violation);
endmodule

bind wp_gate wp_gate_chk #(
    .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR), .KEY1_VALUE(KEY1_VALUE)
) i_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_permit(wr_permit), .unlocked(unlocked), .wr_violation(wr_violation)
);

// File: tb/test_wp_gate.sv
module test_wp_gate;
    localparam logic [31:0] M0 = 32'h83E7_0B13;
    localparam logic [31:0] M1 = 32'h95A4_F1E0;
    localparam logic [7:0]  K0 = 8'h6C;
    localparam logic [7:0]  K1 = 8'h70;

    typedef struct packed {
        logic       valid;
        logic [7:0] addr;
        logic [31:0] data;
        logic       permit;
        logic       unl;
        logic       viol;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 32'h0,        1'b0, 1'b0, 1'b0, 8'd10}, // R10 idle
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd2},  // R2 key0 permitted
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b0, 8'd4},  // R4 opens
        '{1'b1, 8'h10, 32'hABCD,     1'b1, 1'b1, 1'b0, 8'd5},  // R5 open write
        '{1'b1, K0,    32'h0,        1'b1, 1'b0, 1'b0, 8'd6},  // R6 zero closes
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd4},
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b0, 8'd4},
        '{1'b1, K1,    32'h0,        1'b1, 1'b0, 1'b0, 8'd6},  // R6 zero on key1
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd7},
        '{1'b1, K1,    32'h12345678, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 wrong value
        '{1'b1, K1,    M1,           1'b1, 1'b0, 1'b0, 8'd7},  // R7 sequence restarted
        '{1'b1, K1,    M1,           1'b1, 1'b0, 1'b0, 8'd8},  // R8 key1 first
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd8},
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b0, 8'd8},
        '{1'b1, K1,    M1,           1'b1, 1'b0, 1'b0, 8'd8},  // R8 key1 again while open
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd11},
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b0, 8'd11},
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd11}, // R11 re-arm closes
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b0, 8'd11}, // R11 reopens
        '{1'b1, K0,    32'h83E70B12, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 one-bit miss
        '{1'b1, K0,    M0,           1'b1, 1'b0, 1'b0, 8'd9},
        '{1'b1, 8'h20, 32'h5555,     1'b0, 1'b0, 1'b1, 8'd3},  // R3 refused, R9 armed
        '{1'b1, K1,    M1,           1'b1, 1'b1, 1'b1, 8'd9},  // R9 still opens
        '{1'b1, 8'h6D, 32'h1,        1'b1, 1'b1, 1'b1, 8'd12}, // R12 neighbour is ordinary
        '{1'b1, K1,    32'h0,        1'b1, 1'b0, 1'b1, 8'd6},
        '{1'b1, 8'h6D, 32'h0,        1'b0, 1'b0, 1'b1, 8'd12}, // R12 refused when closed
        '{1'b0, K0,    M0,           1'b0, 1'b0, 1'b1, 8'd10}  // R10 no valid, flag sticks
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_permit, unlocked, wr_violation;
    int          n_checks = 0;
    int          n_errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    wp_gate i_wp_gate (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_permit(wr_permit), .unlocked(unlocked), .wr_violation(wr_violation)
    );

    task automatic check(input string what, input int req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #2;
        check("unlocked after reset", 1, unlocked, 1'b0);     // R1
        check("violation after reset", 1, wr_violation, 1'b0); // R1
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_valid = VECS[i].valid;
            wr_addr  = VECS[i].addr;
            wr_data  = VECS[i].data;
            #2;
            check($sformatf("permit step %0d", i), int'(VECS[i].req), wr_permit, VECS[i].permit);
            @(posedge clk);
            #2;
            check($sformatf("unlocked step %0d", i), int'(VECS[i].req), unlocked, VECS[i].unl);
            check($sformatf("violation step %0d", i), int'(VECS[i].req), wr_violation, VECS[i].viol);
        end
        // R10: only reset clears the sticky flag
        @(negedge clk);
        wr_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #2;
        check("violation cleared by reset", 10, wr_violation, 1'b0); // R10
        check("closed after reset", 1, unlocked, 1'b0);               // R1
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule